// File: doc/BRIEF.md
# Set-Associative Cache Lookup

This block is the read path of a cache whose associativity is chosen at build time. The same code covers three shapes. With one way it is direct-mapped. With all lines in one set it is fully associative. Anything in between is a set-associative cache. Each doubling of the way count halves the number of sets, so the tag grows by one bit and the set index shrinks by one bit.

A request address is split, from the top down, into a tag, a set index, a word-within-block field and a two-bit byte-within-word field. The set index is the block address modulo the set count. Every way of the selected set compares its stored tag at the same time, and each comparator also looks at that way's valid bit. The comparators produce a one-hot match vector. That vector is the hit signal, once OR-reduced, and it is also the select of the data multiplexer.

When no way matches, the block stalls and asks a synchronous memory port for the whole block. The returned block goes into an empty way if the set has one, and otherwise into the least recently used way. The requested word is then returned. Every hit and every fill makes the accessed way the most recently used in its set.

Top module: `cache_lookup`

## Requirements
- R1: An address splits as tag | set | word | byte. The byte field is bits [1:0] and is ignored. The word field is the next log2(WORDS) bits and selects the 32-bit word at bits [32*w +: 32] of a block. The set is the block address modulo SETS, and the tag is the block address divided by SETS.
- R2: While rst_ni is low, all valid bits clear, ready_o goes high, and resp_valid_o and mem_req_o go low. After reset, the first access to any block misses.
- R3: A lookup hits only when a way of the indexed set is valid and holds an equal tag. At most one way matches.
- R4: A request is accepted on a rising edge where req_valid_i and ready_o are both high. On a hit, resp_valid_o and resp_hit_o are high in the next cycle, with the addressed word on resp_data_o, and no memory request is made.
- R5: On a miss, mem_req_o is high and ready_o is low from the cycle after acceptance. mem_addr_o carries the block-aligned request address. Both hold until mem_valid_i is seen.
- R6: On a clock edge with mem_req_o and mem_valid_i both high, the block on mem_data_i is stored with its tag and valid bit. In the next cycle resp_valid_o is high, resp_hit_o is low, resp_data_o carries the addressed word, and ready_o is high again.
- R7: The way to refill is the lowest-numbered invalid way of the set. If every way is valid, it is the least recently used way.
- R8: Each hit and each fill makes the accessed way the most recently used in its set. With two ways, alternating between two blocks of the same set 8 times gives exactly 2 misses.
- R9: A request presented while ready_o is low is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request |
| addr_i | input | ADDR_W | Byte address of the request |
| ready_o | output | 1 | Block can accept a request |
| resp_valid_o | output | 1 | Response word valid |
| resp_hit_o | output | 1 | Response came from a hit (1) or a fill (0) |
| resp_data_o | output | 32 | Addressed word |
| mem_req_o | output | 1 | Block fill request |
| mem_addr_o | output | ADDR_W | Block-aligned fill address |
| mem_valid_i | input | 1 | Fill data present |
| mem_data_i | input | WORDS*32 | Fill block, word w at bits [32*w +: 32] |

## Verification
A ping-pong pattern alternates two blocks of one set. It separates working two-way storage (2 misses) from storage that behaves as direct-mapped (8 misses). A third block in the same set then shows whether the refill evicts the least recently used way or the most recent one. Directed accesses that differ only in byte or word bits check the address split. A probe made during a stall checks that requests are refused while the block is busy. Constrained random traffic over a small address range, with random fill latency, compares hit and miss outcomes and data against a timestamp-based reference model.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WORD_W = 32;
  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} cache_state_e;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 10
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            match_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end
endmodule

// File: rtl/cache_way_mux.sv
module cache_way_mux #(
  parameter int WAYS = 2,
  parameter int W    = 64
) (
  input  logic [WAYS-1:0]        sel_i,
  input  logic [WAYS-1:0][W-1:0] lines_i,
  output logic [W-1:0]           line_o
);
  // AND-OR select driven directly by the one-hot match vector
  always_comb begin
    line_o = '0;
    for (int w = 0; w < WAYS; w++) line_o |= lines_i[w] & {W{sel_i[w]}};
  end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_set_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAYS-1:0]  victim_o,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAYS-1:0]  touch_way_i
);
  // per way age: 0 = most recent, WAYS-1 = least recent; ages form a permutation
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAY_W-1:0] touch_age;

  always_comb begin
    touch_age = '0;
    for (int w = 0; w < WAYS; w++)
      if (touch_way_i[w]) touch_age |= age_q[touch_set_i][w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (touch_way_i[w]) age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < touch_age)
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    if (!(&valid_i)) begin
      victim_o = ~valid_i & (valid_i + 1'b1);  // lowest invalid way
    end else begin
      for (int w = 0; w < WAYS; w++)
        victim_o[w] = (age_q[rd_set_i][w] == WAY_W'(WAYS-1));
    end
  end

  AST_VICTIM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(victim_o) == 1); // R7
  AST_TOUCH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |-> $onehot(touch_way_i)); // R8
endmodule

// File: rtl/cache_lookup.sv
module cache_lookup
  import cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WAYS   = 2,
  parameter int LINES  = 8,
  parameter int WORDS  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic                     ready_o,
  output logic                     resp_valid_o,
  output logic                     resp_hit_o,
  output logic [WORD_W-1:0]        resp_data_o,
  output logic                     mem_req_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic                     mem_valid_i,
  input  logic [WORDS*WORD_W-1:0]  mem_data_i
);
  localparam int SETS   = LINES / WAYS;
  localparam int SET_B  = $clog2(SETS);
  localparam int IDX_W  = (SETS > 1) ? SET_B : 1;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int OFF_W  = 2 + $clog2(WORDS);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int TAG_W  = BLK_W - SET_B;
  localparam int LINE_W = WORDS * WORD_W;

  cache_state_e state_q;

  logic [WAYS-1:0]              valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tags_q  [SETS];
  logic [WAYS-1:0][LINE_W-1:0]  lines_q [SETS];

  logic [BLK_W-1:0]  blk_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [WAYS-1:0]   victim_q;

  // request address split
  logic [BLK_W-1:0]  cur_blk;
  logic [IDX_W-1:0]  cur_set, fill_set;
  logic [TAG_W-1:0]  cur_tag, fill_tag;
  logic [WSEL_W-1:0] cur_wsel;

  assign cur_blk  = addr_i[ADDR_W-1:OFF_W];
  assign cur_set  = IDX_W'(cur_blk % SETS);
  assign cur_tag  = TAG_W'(cur_blk >> SET_B);
  assign cur_wsel = WSEL_W'((addr_i >> 2) % WORDS);
  assign fill_set = IDX_W'(blk_q % SETS);
  assign fill_tag = TAG_W'(blk_q >> SET_B);

  logic [WAYS-1:0]   match_oh, victim_oh;
  logic [LINE_W-1:0] hit_line;
  logic              lookup_hit, accept, fill_done;
  logic              touch;
  logic [IDX_W-1:0]  touch_set;
  logic [WAYS-1:0]   touch_way;

  cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i(valid_q[cur_set]), .tags_i(tags_q[cur_set]),
    .tag_i(cur_tag), .match_o(match_oh));

  cache_way_mux #(.WAYS(WAYS), .W(LINE_W)) u_mux (
    .sel_i(match_oh), .lines_i(lines_q[cur_set]), .line_o(hit_line));

  assign lookup_hit = |match_oh;
  assign ready_o    = (state_q == ST_IDLE);
  assign accept     = req_valid_i && ready_o;
  assign mem_req_o  = (state_q == ST_FILL);
  assign fill_done  = mem_req_o && mem_valid_i;
  assign mem_addr_o = {blk_q, OFF_W'(0)};

  assign touch     = (accept && lookup_hit) || fill_done;
  assign touch_set = fill_done ? fill_set : cur_set;
  assign touch_way = fill_done ? victim_q : match_oh;

  cache_lru #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_lru (
    .clk_i, .rst_ni, .rd_set_i(cur_set), .valid_i(valid_q[cur_set]),
    .victim_o(victim_oh), .touch_i(touch), .touch_set_i(touch_set),
    .touch_way_i(touch_way));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_data_o  <= '0;
      blk_q        <= '0;
      wsel_q       <= '0;
      victim_q     <= '0;
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      if (accept) begin
        blk_q    <= cur_blk;
        wsel_q   <= cur_wsel;
        victim_q <= victim_oh;
        if (lookup_hit) begin
          resp_valid_o <= 1'b1;
          resp_hit_o   <= 1'b1;
          resp_data_o  <= hit_line[cur_wsel*WORD_W +: WORD_W];
        end else begin
          state_q <= ST_FILL;
        end
      end else if (fill_done) begin
        state_q               <= ST_IDLE;
        valid_q[fill_set]     <= valid_q[fill_set] | victim_q;
        resp_valid_o          <= 1'b1;
        resp_hit_o            <= 1'b0;
        resp_data_o           <= mem_data_i[wsel_q*WORD_W +: WORD_W];
      end
    end
  end

  // tag and data arrays carry no reset; valid bits gate them
  always_ff @(posedge clk_i) begin
    if (fill_done) begin
      for (int w = 0; w < WAYS; w++)
        if (victim_q[w]) begin
          tags_q[fill_set][w]  <= fill_tag;
          lines_q[fill_set][w] <= mem_data_i;
        end
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_oh)); // R3
  AST_HIT_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && lookup_hit) |=> (resp_valid_o && resp_hit_o && !mem_req_o)); // R4
  AST_MISS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !lookup_hit) |=> (mem_req_o && !ready_o)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R5
  AST_FILL_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> (resp_valid_o && !resp_hit_o && ready_o)); // R6
  AST_NO_BUSY_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> !resp_valid_o); // R9
endmodule

// File: tb/cache_lookup_test.sv
`timescale 1ns/1ps
module cache_lookup_test;
  localparam int ADDR_W = 16;
  localparam int WAYS   = 2;
  localparam int LINES  = 8;
  localparam int WORDS  = 2;
  localparam int SETS   = LINES / WAYS;
  localparam int BLK_BYTES = WORDS * 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic ready_o, resp_valid_o, resp_hit_o, mem_req_o;
  logic [31:0] resp_data_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic mem_valid_i = 1'b0;
  logic [WORDS*32-1:0] mem_data_i = '0;

  always #2.5 clk_i = ~clk_i;

  cache_lookup #(.ADDR_W(ADDR_W), .WAYS(WAYS), .LINES(LINES), .WORDS(WORDS)) uut (
    .clk_i, .rst_ni, .req_valid_i, .addr_i, .ready_o, .resp_valid_o, .resp_hit_o,
    .resp_data_o, .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_data_i);

  int errors = 0, checks = 0, misses = 0, stamp = 0;
  bit ref_valid [SETS][WAYS];
  int ref_tag   [SETS][WAYS];
  int ref_stamp [SETS][WAYS];
  bit last_hit;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input int a);
    return (32'(a) * 32'h0019660D) ^ 32'h3C6EF35F;
  endfunction

  function automatic logic [WORDS*32-1:0] mem_block(input int base);
    logic [WORDS*32-1:0] b;
    for (int i = 0; i < WORDS; i++) b[i*32 +: 32] = mem_word(base + 4*i);
    return b;
  endfunction

  task automatic do_req(input int addr, input int lat, input bit probe);
    int blk, set, tag, way, base;
    logic [31:0] exp_d;
    blk = addr / BLK_BYTES; set = blk % SETS; tag = blk / SETS;
    base = blk * BLK_BYTES;
    exp_d = mem_word(addr & ~3);
    way = -1;
    for (int w = 0; w < WAYS; w++)
      if (ref_valid[set][w] && ref_tag[set][w] == tag) way = w;
    while (!ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; addr_i = ADDR_W'(addr);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    stamp++;
    if (way >= 0) begin
      last_hit = 1'b1;
      check(resp_valid_o && resp_hit_o, "R4 hit flag", {resp_valid_o, resp_hit_o}, 2'b11);
      check(resp_data_o == exp_d, "R4 hit data", resp_data_o, exp_d);
      check(!mem_req_o, "R4 no mem req", mem_req_o, 0);
      ref_stamp[set][way] = stamp;
    end else begin
      last_hit = 1'b0;
      misses++;
      check(mem_req_o && !ready_o && !resp_valid_o, "R5 miss stall",
            {mem_req_o, ready_o, resp_valid_o}, 3'b100);
      check(mem_addr_o == ADDR_W'(base), "R5 fill addr", mem_addr_o, base);
      if (probe) begin
        req_valid_i = 1'b1; addr_i = ADDR_W'(addr ^ 16'h0040);
      end
      for (int i = 0; i < lat; i++) begin
        @(negedge clk_i);
        check(mem_req_o && mem_addr_o == ADDR_W'(base), "R5 hold", mem_addr_o, base);
      end
      req_valid_i = 1'b0;
      mem_valid_i = 1'b1; mem_data_i = mem_block(base);
      @(negedge clk_i);
      mem_valid_i = 1'b0;
      check(resp_valid_o && !resp_hit_o && ready_o, "R6 fill resp",
            {resp_valid_o, resp_hit_o, ready_o}, 3'b101);
      check(resp_data_o == exp_d, "R6 fill data", resp_data_o, exp_d);
      // R7 reference victim: lowest invalid, else oldest stamp
      way = -1;
      for (int w = WAYS-1; w >= 0; w--) if (!ref_valid[set][w]) way = w;
      if (way < 0) begin
        way = 0;
        for (int w = 1; w < WAYS; w++)
          if (ref_stamp[set][w] < ref_stamp[set][way]) way = w;
      end
      ref_valid[set][way] = 1'b1; ref_tag[set][way] = tag; ref_stamp[set][way] = stamp;
      if (probe) begin
        @(negedge clk_i);
        check(!resp_valid_o, "R9 busy request ignored", resp_valid_o, 0);
      end
    end
  endtask

  initial begin
    int m0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check(ready_o && !resp_valid_o && !mem_req_o, "R2 reset outputs",
          {ready_o, resp_valid_o, mem_req_o}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: first touch misses; R1: byte and word fields
    do_req(32'h100, 1, 1'b0);
    check(!last_hit, "R2 first access miss", last_hit, 0);
    do_req(32'h103, 0, 1'b0);
    check(last_hit, "R1 byte offset ignored", last_hit, 1);
    do_req(32'h104, 0, 1'b0);
    check(last_hit, "R1 word in same block", last_hit, 1);
    do_req(32'h100 + BLK_BYTES, 0, 1'b0);
    check(!last_hit, "R1 next block other set", last_hit, 0);

    // R8: ping-pong in set 0
    m0 = misses;
    for (int i = 0; i < 8; i++) do_req((i % 2) ? SETS*BLK_BYTES : 0, 2, 1'b0);
    check(misses - m0 == 2, "R8 ping-pong misses", misses - m0, 2);

    // R7: third block evicts LRU (block 0), keeps block at SETS
    do_req(2*SETS*BLK_BYTES, 1, 1'b0);
    check(!last_hit, "R7 third block miss", last_hit, 0);
    do_req(SETS*BLK_BYTES, 0, 1'b0);
    check(last_hit, "R7 MRU kept", last_hit, 1);
    do_req(0, 0, 1'b0);
    check(!last_hit, "R7 LRU evicted", last_hit, 0);

    // R9: request during stall
    do_req(32'h1F0, 3, 1'b1);

    // random traffic, R3 outcomes via model
    for (int i = 0; i < 400; i++)
      do_req(int'($urandom & 32'h00FF), int'($urandom % 4), ($urandom % 8) == 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule